// File: doc/BRIEF.md
# User Interrupt Posting Engine

This engine performs the send-user-interprocessor-interrupt operation as a sequential state machine. A request carries a 64-bit index into a target table in memory. The engine first checks that the operation is permitted and that the index lies within the table. It then reads the 16-byte table entry and validates it.

A valid entry names a 16-byte posted-interrupt descriptor and a user vector. The engine reads that descriptor under a memory lock, checks its reserved bits, sets the pending bit chosen by the user vector, and decides whether a notification is needed. It writes the descriptor back, which releases the lock. Only after that does it hand a vector and a destination ID to the interprocessor-interrupt sender.

Each accepted request ends in exactly one outcome pulse: done, general-protection fault or invalid-opcode fault. The interrupt controller and the memory system lie outside the block.

Top module: `uipi_post_engine`

## Requirements
- R1: If `uint_en` or `tt_en` is 0, or `mode64` is 0, or `in_enclave` is 1, an accepted request ends in a `fault_ud` pulse and no memory request is made.
- R2: An index strictly greater than `tbl_size` ends in a `fault_gp` pulse with no memory access. An index equal to `tbl_size` proceeds.
- R3: The first memory request of an operation is a read at `tbl_base + (index << 4)`, with 64-bit wrap.
- R4: Table entry layout: valid at bit 0, reserved bits 7:1, user vector at bits 13:8, descriptor address at bits 127:64. If the valid bit is 0 or any reserved bit is 1, the operation ends in `fault_gp` and the descriptor is never accessed.
- R5: The descriptor read and its write-back are made with `mem_lock` high. If descriptor bits 15:2 or 31:24 are nonzero, the operation ends in `fault_gp`, nothing is written and `mem_lock` falls.
- R6: Descriptor layout: outstanding flag at bit 0, suppress flag at bit 1, vector at bits 23:16, destination at bits 63:32, pending bitmap at bits 127:64. The written-back descriptor has bitmap bit `user vector` set, and all other bits are unchanged except as R7 states.
- R7: When both the suppress flag and the outstanding flag are 0, the outstanding flag is set and one notification is sent. Otherwise the flags are written back unchanged and no notification is sent.
- R8: A notification is presented only after the write-back has been acknowledged and `mem_lock` is low. It is held until `ipi_ready`, and done is not pulsed before it is accepted.
- R9: The notification carries the descriptor vector. The destination is the full 32-bit destination field when `x2apic_mode` is 1. Otherwise it is destination bits 15:8, zero-extended.
- R10: While `busy` is high, `req_valid` is ignored: no extra memory access and no extra outcome occurs.
- R11: Every memory request carries `mem_req_sup` = 1.
- R12: Each accepted request produces exactly one of `done`, `fault_gp` or `fault_ud`, each lasting one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_index | input | 64 | Target table index |
| busy | output | 1 | Operation in progress |
| tbl_base | input | 64 | Target table base address |
| tbl_size | input | 64 | Largest permitted index |
| uint_en | input | 1 | Feature enable control bit |
| tt_en | input | 1 | Target-table control enable bit |
| mode64 | input | 1 | Core is in 64-bit mode |
| in_enclave | input | 1 | Core is executing inside an enclave |
| x2apic_mode | input | 1 | Interrupt controller uses 32-bit IDs |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_lock | output | 1 | Lock held over descriptor read-modify-write |
| mem_req_sup | output | 1 | Supervisor-privilege access |
| mem_req_addr | output | 64 | Request address |
| mem_req_wdata | output | 128 | Write data |
| mem_rsp_valid | input | 1 | Read data or write acknowledge |
| mem_rsp_rdata | input | 128 | Read data |
| ipi_valid | output | 1 | Notification request |
| ipi_ready | input | 1 | Sender accepts notification |
| ipi_vector | output | 8 | Notification vector |
| ipi_dest | output | 32 | Notification destination ID |
| done | output | 1 | Successful completion pulse |
| fault_gp | output | 1 | General-protection fault pulse (error code 0) |
| fault_ud | output | 1 | Invalid-opcode fault pulse |

## Verification
A wrong sequencer state shows at the ports within a cycle or two. It appears as a memory request while idle, a lock still high when the notification appears, or a second outcome pulse. A wrong descriptor update is not visible until the write-back data arrives in memory. The bench therefore compares the stored descriptor after every successful operation. A wrong notification decision shows as a missing or extra `ipi_valid` before `done`. A wrong destination selection is caught only when the interrupt-controller mode differs between scenarios.

// File: rtl/uipi_pkg.sv
package uipi_pkg;
  localparam int AW        = 64;   // address and index width
  localparam int LW        = 128;  // table entry / descriptor width
  localparam int UVW       = 6;    // user vector width
  localparam int VW        = 8;    // notification vector width
  localparam int DW        = 32;   // destination width
  localparam int ENT_SHIFT = $clog2(LW / 8);

  // entry fields
  localparam int E_VALID   = 0;
  localparam int E_UV_LO   = 8;
  localparam int E_ADDR_LO = 64;
  // descriptor fields
  localparam int D_ON      = 0;
  localparam int D_SN      = 1;
  localparam int D_NV_LO   = 16;
  localparam int D_DST_LO  = 32;
  localparam int D_PIR_LO  = 64;
  localparam int LEG_LO    = 8;    // legacy id bits within destination
  localparam int LEG_W     = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_ENT_REQ, S_ENT_WAIT, S_DSC_REQ, S_DSC_WAIT,
    S_WR_REQ, S_WR_WAIT, S_NOTE
  } st_e;

  function automatic logic [AW-1:0] ent_addr(input logic [AW-1:0] base,
                                             input logic [AW-1:0] idx);
    return base + (idx << ENT_SHIFT);
  endfunction

  function automatic logic ent_bad(input logic [LW-1:0] e);
    return !e[E_VALID] || (e[7:1] != '0);
  endfunction

  function automatic logic dsc_bad(input logic [LW-1:0] d);
    return (d[15:2] != '0) || (d[31:24] != '0);
  endfunction

  function automatic logic note_needed(input logic [LW-1:0] d);
    return !d[D_ON] && !d[D_SN];
  endfunction

  function automatic logic [LW-1:0] dsc_post(input logic [LW-1:0] d,
                                             input logic [UVW-1:0] uv);
    logic [LW-1:0] r;
    r = d;
    r[D_PIR_LO + int'(uv)] = 1'b1;
    if (note_needed(d)) r[D_ON] = 1'b1;
    return r;
  endfunction

  function automatic logic [DW-1:0] dest_sel(input logic [LW-1:0] d,
                                             input logic x2);
    logic [DW-1:0] full;
    full = d[D_DST_LO +: DW];
    return x2 ? full : {{(DW-LEG_W){1'b0}}, full[LEG_LO +: LEG_W]};
  endfunction
endpackage

// File: rtl/uipi_gate.sv
module uipi_gate
  import uipi_pkg::*;
(
  input  logic          uint_en,
  input  logic          tt_en,
  input  logic          mode64,
  input  logic          in_enclave,
  input  logic [AW-1:0] idx,
  input  logic [AW-1:0] size,
  output logic          perm_ok,
  output logic          range_ok
);
  assign perm_ok  = uint_en && tt_en && mode64 && !in_enclave;
  assign range_ok = !(idx > size);
endmodule

// File: rtl/uipi_entry_chk.sv
module uipi_entry_chk
  import uipi_pkg::*;
(
  input  logic [LW-1:0]  rdata,
  output logic           bad,
  output logic [UVW-1:0] uv,
  output logic [AW-1:0]  dsc_addr
);
  assign bad      = ent_bad(rdata);
  assign uv       = rdata[E_UV_LO +: UVW];
  assign dsc_addr = rdata[E_ADDR_LO +: AW];
endmodule

// File: rtl/uipi_desc_upd.sv
module uipi_desc_upd
  import uipi_pkg::*;
(
  input  logic [LW-1:0]  rdata,
  input  logic [UVW-1:0] uv,
  input  logic           x2,
  output logic           bad,
  output logic [LW-1:0]  new_dsc,
  output logic           send,
  output logic [VW-1:0]  vector,
  output logic [DW-1:0]  dest
);
  assign bad     = dsc_bad(rdata);
  assign new_dsc = dsc_post(rdata, uv);
  assign send    = note_needed(rdata);
  assign vector  = rdata[D_NV_LO +: VW];
  assign dest    = dest_sel(rdata, x2);
endmodule

// File: rtl/uipi_post_engine.sv
module uipi_post_engine
  import uipi_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [63:0]   req_index,
  output logic          busy,
  input  logic [63:0]   tbl_base,
  input  logic [63:0]   tbl_size,
  input  logic          uint_en,
  input  logic          tt_en,
  input  logic          mode64,
  input  logic          in_enclave,
  input  logic          x2apic_mode,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic          mem_lock,
  output logic          mem_req_sup,
  output logic [63:0]   mem_req_addr,
  output logic [127:0]  mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [127:0]  mem_rsp_rdata,
  output logic          ipi_valid,
  input  logic          ipi_ready,
  output logic [7:0]    ipi_vector,
  output logic [31:0]   ipi_dest,
  output logic          done,
  output logic          fault_gp,
  output logic          fault_ud
);
  st_e state;

  logic [AW-1:0]  ent_addr_q, dsc_addr_q;
  logic [UVW-1:0] uv_q;
  logic [LW-1:0]  new_q;
  logic           send_q;
  logic [VW-1:0]  vec_q;
  logic [DW-1:0]  dest_q;
  logic           done_q, gp_q, ud_q;

  // named internal events
  logic           perm_ok, range_ok;
  logic           accept_w;
  logic           ent_rsp_w, dsc_rsp_w, wr_ack_w;
  logic           e_bad, d_bad, d_send;
  logic           ent_bad_evt, dsc_bad_evt;
  logic [UVW-1:0] e_uv;
  logic [AW-1:0]  e_daddr;
  logic [LW-1:0]  d_new;
  logic [VW-1:0]  d_vec;
  logic [DW-1:0]  d_dest;

  uipi_gate u_gate (
    .uint_en(uint_en), .tt_en(tt_en), .mode64(mode64), .in_enclave(in_enclave),
    .idx(req_index), .size(tbl_size), .perm_ok(perm_ok), .range_ok(range_ok)
  );

  uipi_entry_chk u_ent (
    .rdata(mem_rsp_rdata), .bad(e_bad), .uv(e_uv), .dsc_addr(e_daddr)
  );

  uipi_desc_upd u_dsc (
    .rdata(mem_rsp_rdata), .uv(uv_q), .x2(x2apic_mode), .bad(d_bad),
    .new_dsc(d_new), .send(d_send), .vector(d_vec), .dest(d_dest)
  );

  assign accept_w    = req_valid && (state == S_IDLE);
  assign ent_rsp_w   = mem_rsp_valid && (state == S_ENT_WAIT);
  assign dsc_rsp_w   = mem_rsp_valid && (state == S_DSC_WAIT);
  assign wr_ack_w    = mem_rsp_valid && (state == S_WR_WAIT);
  assign ent_bad_evt = ent_rsp_w && e_bad;
  assign dsc_bad_evt = dsc_rsp_w && d_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      ent_addr_q <= '0;
      dsc_addr_q <= '0;
      uv_q       <= '0;
      new_q      <= '0;
      send_q     <= 1'b0;
      vec_q      <= '0;
      dest_q     <= '0;
      done_q     <= 1'b0;
      gp_q       <= 1'b0;
      ud_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      gp_q   <= 1'b0;
      ud_q   <= 1'b0;
      unique case (state)
        S_IDLE: if (accept_w) begin
          if (!perm_ok)       ud_q <= 1'b1;
          else if (!range_ok) gp_q <= 1'b1;
          else begin
            ent_addr_q <= ent_addr(tbl_base, req_index);
            state      <= S_ENT_REQ;
          end
        end
        S_ENT_REQ: if (mem_req_ready) state <= S_ENT_WAIT;
        S_ENT_WAIT: if (ent_rsp_w) begin
          if (e_bad) begin
            gp_q  <= 1'b1;
            state <= S_IDLE;
          end else begin
            dsc_addr_q <= e_daddr;
            uv_q       <= e_uv;
            state      <= S_DSC_REQ;
          end
        end
        S_DSC_REQ: if (mem_req_ready) state <= S_DSC_WAIT;
        S_DSC_WAIT: if (dsc_rsp_w) begin
          if (d_bad) begin
            gp_q  <= 1'b1;
            state <= S_IDLE;
          end else begin
            new_q  <= d_new;
            send_q <= d_send;
            vec_q  <= d_vec;
            dest_q <= d_dest;
            state  <= S_WR_REQ;
          end
        end
        S_WR_REQ: if (mem_req_ready) state <= S_WR_WAIT;
        S_WR_WAIT: if (wr_ack_w) begin
          if (send_q) state <= S_NOTE;
          else begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end
        end
        S_NOTE: if (ipi_ready) begin
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy          = (state != S_IDLE);
  assign mem_req_valid = (state == S_ENT_REQ) || (state == S_DSC_REQ) ||
                         (state == S_WR_REQ);
  assign mem_req_write = (state == S_WR_REQ);
  assign mem_lock      = (state == S_DSC_REQ) || (state == S_DSC_WAIT) ||
                         (state == S_WR_REQ)  || (state == S_WR_WAIT);
  assign mem_req_sup   = 1'b1;
  assign mem_req_addr  = (state == S_ENT_REQ) ? ent_addr_q : dsc_addr_q;
  assign mem_req_wdata = new_q;
  assign ipi_valid     = (state == S_NOTE);
  assign ipi_vector    = vec_q;
  assign ipi_dest      = dest_q;
  assign done          = done_q;
  assign fault_gp      = gp_q;
  assign fault_ud      = ud_q;
endmodule

// File: rtl/uipi_post_engine_chk.sv
module uipi_post_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mem_req_valid,
  input logic        mem_req_write,
  input logic        mem_lock,
  input logic        ipi_valid,
  input logic        ipi_ready,
  input logic [7:0]  ipi_vector,
  input logic [31:0] ipi_dest,
  input logic        done,
  input logic        fault_gp,
  input logic        fault_ud,
  input logic        accept_w,
  input logic        ent_bad_evt
);
  AST_UD_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_ud |-> $past(accept_w));  // R1
  AST_ENT_FAULT_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ent_bad_evt |=> !mem_lock);  // R4
  AST_WRITE_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> mem_lock);  // R5
  AST_NOTE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_valid |-> !mem_lock);  // R8
  AST_NOTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ipi_valid && !ipi_ready) |=> (ipi_valid && $stable(ipi_vector) && $stable(ipi_dest)));  // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req_valid && !mem_lock && !ipi_valid));  // R10
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fault_gp, fault_ud}));  // R12
  AST_OUTCOME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault_gp || fault_ud) |=> !(done || fault_gp || fault_ud));  // R12
endmodule

bind uipi_post_engine uipi_post_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req_valid(mem_req_valid),
  .mem_req_write(mem_req_write), .mem_lock(mem_lock), .ipi_valid(ipi_valid),
  .ipi_ready(ipi_ready), .ipi_vector(ipi_vector), .ipi_dest(ipi_dest),
  .done(done), .fault_gp(fault_gp), .fault_ud(fault_ud),
  .accept_w(accept_w), .ent_bad_evt(ent_bad_evt)
);

// File: tb/uipi_post_engine_test.sv
`timescale 1ns/1ps
module uipi_post_engine_test;
  localparam logic [63:0] TB = 64'h1000;
  localparam logic [63:0] DB = 64'h8000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [63:0] req_index = '0;
  logic busy;
  logic [63:0] tbl_base = TB, tbl_size = 64'd15;
  logic uint_en = 1'b1, tt_en = 1'b1, mode64 = 1'b1, in_enclave = 1'b0;
  logic x2apic_mode = 1'b1;
  logic mem_req_valid, mem_req_write, mem_lock, mem_req_sup;
  logic mem_req_ready = 1'b1;
  logic [63:0] mem_req_addr;
  logic [127:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [127:0] mem_rsp_rdata = '0;
  logic ipi_valid;
  logic ipi_ready = 1'b1;
  logic [7:0] ipi_vector;
  logic [31:0] ipi_dest;
  logic done, fault_gp, fault_ud;

  uipi_post_engine uut (.*);

  int n_chk = 0, n_fail = 0;
  int n_acc, n_wr, n_ipi, n_out;
  logic [63:0] first_addr;
  logic sup_bad, lock_at_ipi, unlocked_dsc;
  int wr_at_ipi;
  logic [7:0] seen_vec;
  logic [31:0] seen_dest;
  logic pulse_ok;
  logic [127:0] ent_mem [0:15];
  logic [127:0] dsc_mem [0:3];

  function automatic logic [127:0] mk_ent(input logic v, input logic [6:0] rsv,
      input logic [5:0] uv, input logic [63:0] da);
    logic [127:0] e = '0;
    e[0] = v; e[7:1] = rsv; e[13:8] = uv; e[127:64] = da;
    return e;
  endfunction

  function automatic logic [127:0] mk_dsc(input logic on, input logic sn,
      input logic [13:0] r1, input logic [7:0] r2, input logic [7:0] nv,
      input logic [31:0] ndst, input logic [63:0] pir);
    logic [127:0] d = '0;
    d[0] = on; d[1] = sn; d[15:2] = r1; d[23:16] = nv; d[31:24] = r2;
    d[63:32] = ndst; d[127:64] = pir;
    return d;
  endfunction

  // memory and sender model
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (n_acc == 0) first_addr = mem_req_addr;
      n_acc++;
      if (!mem_req_sup) sup_bad = 1'b1;
      if (mem_req_addr >= DB && !mem_lock) unlocked_dsc = 1'b1;
      mem_rsp_valid <= 1'b1;
      if (mem_req_write) begin
        n_wr++;
        if (mem_req_addr >= DB && mem_req_addr < DB + 64)
          dsc_mem[2'((mem_req_addr - DB) >> 4)] = mem_req_wdata;
      end else if (mem_req_addr >= TB && mem_req_addr < TB + 256)
        mem_rsp_rdata <= ent_mem[4'((mem_req_addr - TB) >> 4)];
      else if (mem_req_addr >= DB && mem_req_addr < DB + 64)
        mem_rsp_rdata <= dsc_mem[2'((mem_req_addr - DB) >> 4)];
      else
        mem_rsp_rdata <= '0;
    end
    if (ipi_valid && ipi_ready) begin
      n_ipi++;
      seen_vec = ipi_vector; seen_dest = ipi_dest;
      wr_at_ipi = n_wr; lock_at_ipi = mem_lock;
    end
    if (rst_n && (done || fault_gp || fault_ud)) n_out++;
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr();
    @(negedge clk);
    n_acc = 0; n_wr = 0; n_ipi = 0; n_out = 0; first_addr = '0;
    sup_bad = 0; lock_at_ipi = 0; unlocked_dsc = 0; wr_at_ipi = -1;
    seen_vec = '0; seen_dest = '0;
    uint_en = 1; tt_en = 1; mode64 = 1; in_enclave = 0; ipi_ready = 1;
  endtask

  // returns {ud, gp, done}
  task automatic run_op(input logic [63:0] idx, output logic [2:0] res);
    @(negedge clk);
    req_valid = 1'b1; req_index = idx;
    @(negedge clk);
    req_valid = 1'b0;
    res = '0;
    for (int i = 0; i < 200 && res == '0; i++) begin
      if (done || fault_gp || fault_ud) res = {fault_ud, fault_gp, done};
      else @(negedge clk);
    end
    @(negedge clk);
    pulse_ok = !(done || fault_gp || fault_ud);
  endtask

  task automatic t_reset();
    chk("R12 reset outcomes", {done, fault_gp, fault_ud}, 3'b000);
    chk("R10 reset idle", {busy, mem_req_valid, mem_lock, ipi_valid}, 4'b0000);
  endtask

  task automatic t_perm();
    logic [2:0] r;
    for (int k = 0; k < 4; k++) begin
      clr();
      ent_mem[1] = mk_ent(1, 0, 0, DB);
      if (k == 0) uint_en = 0;
      if (k == 1) tt_en = 0;
      if (k == 2) mode64 = 0;
      if (k == 3) in_enclave = 1;
      run_op(64'd1, r);
      chk("R1 invalid-opcode", r, 3'b100);
      chk("R1 no memory access", n_acc, 0);
    end
  endtask

  task automatic t_range();
    logic [2:0] r;
    clr(); run_op(64'd16, r);
    chk("R2 index above size", {r, 32'(n_acc)}, {3'b010, 32'd0});
    clr(); run_op(64'hFFFF_FFFF_0000_0003, r);
    chk("R2 huge index", {r, 32'(n_acc)}, {3'b010, 32'd0});
  endtask

  task automatic t_post_x2();
    logic [2:0] r;
    clr(); x2apic_mode = 1;
    ent_mem[3] = mk_ent(1, 0, 6'd5, DB);
    dsc_mem[0] = mk_dsc(0, 0, 0, 0, 8'h42, 32'h1234_5678, 64'h0);
    run_op(64'd3, r);
    chk("R12 done outcome", r, 3'b001);
    chk("R12 single-cycle pulse", pulse_ok, 1'b1);
    chk("R3 entry address", first_addr, TB + 64'h30);
    chk("R6 R7 descriptor written", dsc_mem[0],
        mk_dsc(1, 0, 0, 0, 8'h42, 32'h1234_5678, 64'h20));
    chk("R7 one notification", n_ipi, 1);
    chk("R9 vector and x2 destination", {seen_vec, seen_dest}, {8'h42, 32'h1234_5678});
    chk("R8 after write, unlocked", {32'(wr_at_ipi), 1'(lock_at_ipi)}, {32'd1, 1'b0});
    chk("R5 descriptor accesses locked", unlocked_dsc, 1'b0);
    chk("R11 supervisor", sup_bad, 1'b0);
  endtask

  task automatic t_post_legacy();
    logic [2:0] r;
    clr(); x2apic_mode = 0;
    ent_mem[15] = mk_ent(1, 0, 6'd63, DB + 16);
    dsc_mem[1] = mk_dsc(0, 0, 0, 0, 8'h9A, 32'hAABB_CCDD, 64'h1);
    run_op(64'd15, r);
    chk("R2 index equal to size", r, 3'b001);
    chk("R3 last entry address", first_addr, TB + 64'hF0);
    chk("R6 top pending bit", dsc_mem[1],
        mk_dsc(1, 0, 0, 0, 8'h9A, 32'hAABB_CCDD, 64'h8000_0000_0000_0001));
    chk("R9 legacy destination", {seen_vec, seen_dest}, {8'h9A, 32'h0000_00CC});
  endtask

  task automatic t_on_set();
    logic [2:0] r;
    clr();
    ent_mem[2] = mk_ent(1, 0, 6'd7, DB + 32);
    dsc_mem[2] = mk_dsc(1, 0, 0, 0, 8'h11, 32'h5, 64'h1);
    run_op(64'd2, r);
    chk("R7 outstanding: done", r, 3'b001);
    chk("R7 outstanding: no notification", n_ipi, 0);
    chk("R6 outstanding: bitmap", dsc_mem[2], mk_dsc(1, 0, 0, 0, 8'h11, 32'h5, 64'h81));
  endtask

  task automatic t_suppress();
    logic [2:0] r;
    clr();
    ent_mem[4] = mk_ent(1, 0, 6'd33, DB + 48);
    dsc_mem[3] = mk_dsc(0, 1, 0, 0, 8'h22, 32'h7, 64'h0);
    run_op(64'd4, r);
    chk("R7 suppressed: done", r, 3'b001);
    chk("R7 suppressed: no notification", n_ipi, 0);
    chk("R7 suppressed: flags kept", dsc_mem[3],
        mk_dsc(0, 1, 0, 0, 8'h22, 32'h7, 64'h2_0000_0000));
  endtask

  task automatic t_entry_bad();
    logic [2:0] r;
    clr(); ent_mem[5] = mk_ent(0, 0, 6'd1, DB);
    run_op(64'd5, r);
    chk("R4 invalid entry", {r, 32'(n_acc)}, {3'b010, 32'd1});
    clr(); ent_mem[6] = mk_ent(1, 7'h40, 6'd1, DB);
    run_op(64'd6, r);
    chk("R4 reserved entry bit", {r, 32'(n_acc)}, {3'b010, 32'd1});
  endtask

  task automatic t_desc_bad();
    logic [2:0] r;
    logic [127:0] d;
    clr();
    d = mk_dsc(0, 0, 14'h0004, 0, 8'h1, 32'h1, 64'h0);
    dsc_mem[0] = d; ent_mem[7] = mk_ent(1, 0, 6'd2, DB);
    run_op(64'd7, r);
    chk("R5 reserved 15:2", {r, 32'(n_wr)}, {3'b010, 32'd0});
    chk("R5 descriptor unchanged", dsc_mem[0], d);
    chk("R5 lock released", {mem_lock, busy}, 2'b00);
    clr();
    d = mk_dsc(0, 0, 0, 8'h80, 8'h1, 32'h1, 64'h0);
    dsc_mem[0] = d;
    run_op(64'd7, r);
    chk("R5 reserved 31:24", {r, 32'(n_wr), 32'(n_ipi)}, {3'b010, 32'd0, 32'd0});
  endtask

  task automatic t_busy();
    clr();
    ent_mem[8] = mk_ent(1, 0, 6'd0, DB + 16);
    dsc_mem[1] = mk_dsc(1, 0, 0, 0, 8'h3, 32'h3, 64'h0);
    @(negedge clk); req_valid = 1; req_index = 64'd8;
    @(negedge clk); req_index = 64'd99;           // would fault if taken
    repeat (4) @(negedge clk);
    req_valid = 0;
    repeat (20) @(negedge clk);
    chk("R10 single operation accesses", n_acc, 3);
    chk("R10 single outcome", n_out, 1);
  endtask

  task automatic t_stall();
    clr(); x2apic_mode = 1; ipi_ready = 0;
    ent_mem[9] = mk_ent(1, 0, 6'd9, DB + 16);
    dsc_mem[1] = mk_dsc(0, 0, 0, 0, 8'h77, 32'hCAFE_0001, 64'h0);
    @(negedge clk); req_valid = 1; req_index = 64'd9;
    @(negedge clk); req_valid = 0;
    for (int i = 0; i < 50 && !ipi_valid; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R8 held while not ready", {ipi_valid, done, mem_lock}, 3'b100);
    chk("R9 held values", {ipi_vector, ipi_dest}, {8'h77, 32'hCAFE_0001});
    ipi_ready = 1;
    @(negedge clk);
    chk("R8 done after acceptance", {done, ipi_valid}, 2'b10);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) ent_mem[i] = '0;
    for (int i = 0; i < 4; i++) dsc_mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_perm();
    t_range();
    t_post_x2();
    t_post_legacy();
    t_on_set();
    t_suppress();
    t_entry_bad();
    t_desc_bad();
    t_busy();
    t_stall();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule